// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches virtual-to-physical page translations for a 32-bit address space with 4 KB pages. A lookup request carries a full virtual address. Its upper 20 bits form the virtual page number (VPN) and its lower 12 bits form the page offset. The VPN is compared against every stored tag at the same time. On a hit, the physical address is the stored frame number with the offset appended unchanged. On a miss, the response reports no hit, and whatever agent walks the page tables supplies the translation through the refill port.

Refills go into the lowest-numbered empty slot while one exists. Once the cache is full, a refill replaces the least-recently-used slot. A refill whose VPN is already cached rewrites that slot in place. Two plain maintenance controls keep the cache consistent with the page tables. One drops a single page after its mapping or protection changes. The other empties the whole cache on an address-space switch.

Lookups use valid/ready on both sides. A request is accepted on a clock edge where `lk_valid` and `lk_ready` are both high, and its response is presented on the next cycle. The response holds its value and stays valid until `rsp_ready` is seen high. While a response is stalled, `lk_ready` is low. `lk_ready` is also low in any cycle with refill, invalidate or flush activity, because maintenance takes priority over lookups.

Top module: `xlat_cache`

## Requirements
- R1: After reset all 8 slots are empty, `rsp_valid` is 0, `lk_ready` is 1, and any lookup misses.
- R2: The address splits as VPN = bits 31:12 and offset = bits 11:0. On a hit, `rsp_paddr` = {frame number, offset}, with the offset unchanged.
- R3: A lookup accepted at edge N presents `rsp_valid`=1 after edge N, with `rsp_hit`=1 when its VPN is cached.
- R4: A lookup of an uncached VPN responds with `rsp_hit`=0 and `rsp_paddr`=0.
- R5: While empty slots exist, a refill fills one of them. Eight refills of distinct VPNs into an empty cache leave all eight cached.
- R6: A refill into a full cache evicts the least-recently-used slot and keeps all the others.
- R7: A hit or a refill makes that slot most-recently-used. A miss leaves the recency order unchanged.
- R8: A refill of a VPN that is already cached overwrites its frame number in the same slot and creates no duplicate.
- R9: An invalidate removes only the slot whose VPN matches. An invalidate of an uncached VPN changes nothing.
- R10: A flush empties every slot in one cycle.
- R11: While `rsp_valid`=1 and `rsp_ready`=0, the response holds `rsp_hit` and `rsp_paddr` stable, and `lk_ready`=0.
- R12: `lk_ready`=0 in any cycle where `fill_valid`, `inv_valid` or `flush` is high. Flush takes priority over invalidate, and invalidate over refill (`fill_ready`=0 while either is high), and only the highest-priority action takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 32 | Physical address on a hit, 0 on a miss |
| fill_valid | input | 1 | Refill request valid |
| fill_ready | output | 1 | Refill accepted this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| inv_valid | input | 1 | Drop the slot holding `inv_vpn` |
| inv_vpn | input | 20 | Virtual page number to drop |
| flush | input | 1 | Empty the whole cache |

## Verification
The bench fills the cache and then reorders recency with hits and misses, so that a design which touched a slot on a miss, or which evicted by slot index instead of by age, would remove the wrong page. It refills a VPN that is already cached and then fills the remaining slots. A design that created a duplicate would lose an older page early, or return a stale frame. Invalidates of present and absent pages, flushes, a stalled response and cycles with overlapping maintenance requests expose wrong ordering between these controls. Such a design would let a lookup or refill slip through, or drop the response.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned XL_VA_W    = 32;
  localparam int unsigned XL_PA_W    = 32;
  localparam int unsigned XL_OFF_W   = 12;
  localparam int unsigned XL_ENTRIES = 8;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int unsigned N  = 8,
  parameter int unsigned KW = 20,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][KW-1:0] tags,
  input  logic [KW-1:0]        key,
  output logic [N-1:0]         vec,
  output logic                 hit,
  output logic [IW-1:0]        idx
);
  // compare every slot at once
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign vec[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid,
  output logic [IW-1:0] victim
);
  // age 0 = most recent, N-1 = oldest; ages always form a permutation
  logic [IW-1:0] age [N];
  logic [N-1:0]  oldest;
  logic          any_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (age[g] == IW'(N - 1));
  end

  always_comb begin
    victim   = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        victim   = IW'(i);
        any_free = 1'b1;
      end
    end
    if (!any_free) begin
      for (int i = 0; i < N; i++) begin
        if (oldest[i]) victim = IW'(i);
      end
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1); // R6
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W    = XL_VA_W,
  parameter int unsigned PA_W    = XL_PA_W,
  parameter int unsigned OFF_W   = XL_OFF_W,
  parameter int unsigned ENTRIES = XL_ENTRIES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  output logic                   lk_ready,
  input  logic [VA_W-1:0]        lk_vaddr,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_hit,
  output logic [PA_W-1:0]        rsp_paddr,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PA_W-OFF_W-1:0]  fill_pfn,
  input  logic                   inv_valid,
  input  logic [VA_W-OFF_W-1:0]  inv_vpn,
  input  logic                   flush
);
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PFN_W = PA_W - OFF_W;
  localparam int unsigned IW    = $clog2(ENTRIES);

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;

  logic [ENTRIES-1:0] l_vec, m_vec;
  logic               l_hit, m_hit;
  logic [IW-1:0]      l_idx, m_idx, victim, fill_idx, touch_idx;
  logic [VPN_W-1:0]   mnt_key;
  logic               lk_fire, fill_fire, inv_fire, touch;

  // handshake and maintenance priority: flush > invalidate > refill > lookup
  assign lk_ready   = (!rsp_valid || rsp_ready) && !fill_valid && !inv_valid && !flush;
  assign fill_ready = !inv_valid && !flush;
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_fire  = fill_valid && fill_ready;
  assign inv_fire   = inv_valid && !flush;
  assign mnt_key    = inv_valid ? inv_vpn : fill_vpn;

  xlat_match #(.N(ENTRIES), .KW(VPN_W), .IW(IW)) i_lk_match (
    .valid(valid_q), .tags(tag_q), .key(lk_vaddr[VA_W-1:OFF_W]),
    .vec(l_vec), .hit(l_hit), .idx(l_idx)
  );

  xlat_match #(.N(ENTRIES), .KW(VPN_W), .IW(IW)) i_mnt_match (
    .valid(valid_q), .tags(tag_q), .key(mnt_key),
    .vec(m_vec), .hit(m_hit), .idx(m_idx)
  );

  assign fill_idx  = m_hit ? m_idx : victim;
  assign touch     = (lk_fire && l_hit) || fill_fire;
  assign touch_idx = fill_fire ? fill_idx : l_idx;

  xlat_lru #(.N(ENTRIES), .IW(IW)) i_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
    .valid(valid_q), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (inv_fire) begin
      if (m_hit) valid_q[m_idx] <= 1'b0;
    end else if (fill_fire) begin
      valid_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[fill_idx] <= fill_vpn;
      pfn_q[fill_idx] <= fill_pfn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= l_hit;
      rsp_paddr <= l_hit ? {pfn_q[l_idx], lk_vaddr[OFF_W-1:0]} : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit)); // R11
  AST_LK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_vec)); // R8
  AST_MNT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_vec)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !l_hit && !m_hit); // R10
  AST_INV_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire && m_hit |=> !valid_q[$past(m_idx)]); // R9
endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_ready, rsp_valid, rsp_ready, rsp_hit;
  logic [31:0] lk_vaddr, rsp_paddr;
  logic        fill_valid, fill_ready, inv_valid, flush;
  logic [19:0] fill_vpn, fill_pfn, inv_vpn;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_vaddr(lk_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush(flush)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                        output logic hit, output logic [31:0] pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; rsp_ready = 1'b1;
    @(posedge clk); #2;
    lk_valid = 1'b0;
    hit = rsp_hit; pa = rsp_paddr;
  endtask

  task automatic expect_hit(input string rq, input logic [19:0] vpn, input logic [19:0] pfn);
    logic h; logic [31:0] pa;
    lookup(vpn, 12'h5A3, h, pa);
    chk(rq, {31'd0, h}, 32'd1);
    chk(rq, pa, {pfn, 12'h5A3});
  endtask

  task automatic expect_miss(input string rq, input logic [19:0] vpn);
    logic h; logic [31:0] pa;
    lookup(vpn, 12'h0F0, h, pa);
    chk(rq, {31'd0, h}, 32'd0);
    chk(rq, pa, 32'd0);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
    @(posedge clk); #2;
    fill_valid = 1'b0;
  endtask

  task automatic inval(input logic [19:0] vpn);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = vpn;
    @(posedge clk); #2;
    inv_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #2; flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 lk_ready", {31'd0, lk_ready}, 32'd1);
    expect_miss("R1 empty", 20'h00000);
    expect_miss("R1 empty", 20'hABCDE);
  endtask

  task automatic t_hit_split();
    logic h; logic [31:0] pa;
    do_flush();
    fill(20'h12345, 20'h0BEEF);
    lookup(20'h12345, 12'h000, h, pa);
    chk("R3 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R3 hit", {31'd0, h}, 32'd1);
    chk("R2 paddr low", pa, 32'h0BEEF000);
    lookup(20'h12345, 12'hFFF, h, pa);
    chk("R2 paddr high", pa, 32'h0BEEFFFF);
    expect_miss("R4 other page", 20'h12344);
  endtask

  task automatic t_lru();
    do_flush();
    for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h00500 + 20'(i));
    for (int i = 0; i < 8; i++) expect_hit("R5 all stored", 20'h00100 + 20'(i), 20'h00500 + 20'(i));
    expect_hit("R6 touch", 20'h00100, 20'h00500);
    fill(20'h00200, 20'h00900);
    expect_miss("R6 lru evicted", 20'h00101);
    expect_hit("R6 new", 20'h00200, 20'h00900);
    expect_hit("R6 kept", 20'h00100, 20'h00500);
    expect_hit("R6 kept", 20'h00107, 20'h00507);
  endtask

  task automatic t_mru_miss();
    do_flush();
    for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h00500 + 20'(i));
    expect_hit("R7 touch", 20'h00102, 20'h00502);
    expect_miss("R7 miss", 20'h003FF);
    fill(20'h00300, 20'h00A00);
    expect_miss("R7 oldest evicted", 20'h00100);
    expect_hit("R7 kept", 20'h00101, 20'h00501);
    expect_hit("R7 kept", 20'h00102, 20'h00502);
  endtask

  task automatic t_dup();
    do_flush();
    fill(20'h00400, 20'h00111);
    fill(20'h00400, 20'h00222);
    expect_hit("R8 overwrite", 20'h00400, 20'h00222);
    for (int i = 1; i < 8; i++) fill(20'h00400 + 20'(i), 20'h00700 + 20'(i));
    expect_hit("R8 no dup", 20'h00400, 20'h00222);
    for (int i = 1; i < 8; i++) expect_hit("R8 no dup", 20'h00400 + 20'(i), 20'h00700 + 20'(i));
  endtask

  task automatic t_inv();
    do_flush();
    fill(20'h01000, 20'h00010);
    fill(20'h01001, 20'h00011);
    fill(20'h01002, 20'h00012);
    inval(20'h01001);
    expect_miss("R9 removed", 20'h01001);
    expect_hit("R9 kept", 20'h01000, 20'h00010);
    expect_hit("R9 kept", 20'h01002, 20'h00012);
    inval(20'h07777);
    expect_hit("R9 absent no effect", 20'h01000, 20'h00010);
    expect_hit("R9 absent no effect", 20'h01002, 20'h00012);
  endtask

  task automatic t_flush();
    fill(20'h02000, 20'h00020);
    fill(20'h02001, 20'h00021);
    expect_hit("R10 before", 20'h02000, 20'h00020);
    do_flush();
    expect_miss("R10 flushed", 20'h02000);
    expect_miss("R10 flushed", 20'h02001);
    expect_miss("R10 flushed", 20'h01000);
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    do_flush();
    fill(20'h03000, 20'h00030);
    fill(20'h03001, 20'h00031);
    @(negedge clk);
    rsp_ready = 1'b0; lk_valid = 1'b1; lk_vaddr = 32'h03000123;
    @(posedge clk); #2;
    held = rsp_paddr;
    chk("R11 first", held, 32'h00030123);
    lk_vaddr = 32'h03001456;
    #1;
    chk("R11 lk_ready low", {31'd0, lk_ready}, 32'd0);
    @(posedge clk); @(posedge clk); #2;
    chk("R11 held valid", {31'd0, rsp_valid}, 32'd1);
    chk("R11 held paddr", rsp_paddr, held);
    @(negedge clk);
    rsp_ready = 1'b1;
    #1;
    chk("R11 ready back", {31'd0, lk_ready}, 32'd1);
    @(posedge clk); #2;
    lk_valid = 1'b0;
    chk("R11 second", rsp_paddr, 32'h00031456);
  endtask

  task automatic t_priority();
    do_flush();
    fill(20'h04000, 20'h00040);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = 20'h04000;
    fill_valid = 1'b1; fill_vpn = 20'h04001; fill_pfn = 20'h00041;
    lk_valid = 1'b1; lk_vaddr = 32'h04000000; rsp_ready = 1'b1;
    #1;
    chk("R12 lk blocked", {31'd0, lk_ready}, 32'd0);
    chk("R12 fill blocked", {31'd0, fill_ready}, 32'd0);
    @(posedge clk); #2;
    chk("R12 no lookup rsp", {31'd0, rsp_valid}, 32'd0);
    inv_valid = 1'b0; fill_valid = 1'b0; lk_valid = 1'b0;
    expect_miss("R12 inv applied", 20'h04000);
    expect_miss("R12 fill dropped", 20'h04001);
    fill(20'h04002, 20'h00042);
    @(negedge clk);
    flush = 1'b1; inv_valid = 1'b1; inv_vpn = 20'h07777;
    fill_valid = 1'b1; fill_vpn = 20'h04003; fill_pfn = 20'h00043;
    #1;
    chk("R12 flush blocks fill", {31'd0, fill_ready}, 32'd0);
    @(posedge clk); #2;
    flush = 1'b0; inv_valid = 1'b0; fill_valid = 1'b0;
    expect_miss("R12 flush wins", 20'h04002);
    expect_miss("R12 flush wins", 20'h04003);
  endtask

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; rsp_ready = 1'b1;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0;
    inv_valid = 1'b0; inv_vpn = '0; flush = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_hit_split();
    t_lru();
    t_mru_miss();
    t_dup();
    t_inv();
    t_flush();
    t_backpressure();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule